// File: doc/BRIEF.md
# Multicore Run-State and System-Call Controller

This block holds the run flag of each processor core in a small cluster and carries out the system calls that those cores retire. Each core presents its system call in the writeback stage. It supplies the immediate value, the PC of the calling instruction and the current value of its R1. The controller acts on the call in that same cycle. It can start an idle core, stop the calling core, or raise a console-output strobe. When a start succeeds, the controller issues a PC load and R1 write-enables that give fork-like results: the new core sees R1 = 1 and the caller sees R1 = 0.

The controller also produces the decode-stage stall that makes every system call pass through its pipeline alone. A system call waiting in decode is held while any older instruction remains in execute, memory or writeback. Any instruction in decode is held while a system call occupies one of those stages. The all-halted output tells the surrounding system that every core has stopped.

Top module: `core_run_ctrl`

## Requirements
- R1: After synchronous active-low reset, only core 0 has its run flag set and all_halted is 0.
- R2: A writeback call from a running core with immediate N, where 1 <= N < NCORES, aimed at an idle core N, asserts pc_load_en[N] in that cycle with pc_load_val[N] equal to the caller's PC plus 4. It also asserts r1_we[N] with r1_wdata[N] = 1.
- R3: In the cycle of a successful start, the calling core receives r1_we = 1 with r1_wdata = 0.
- R4: A started core's run flag is 1 from the cycle after the start.
- R5: Immediate 10 clears the run flag of the calling core only, from the next cycle.
- R6: all_halted is 1 exactly when every run flag is 0. Once set, it stays set until reset.
- R7: Immediate 11 asserts print_en of the calling core in that cycle, with print_data equal to that core's R1. The core number is the strobe's position.
- R8: dec_stall[i] is 1 when decode of core i holds a system call (dec_sys[i]) while back_busy[i] reports any instruction in execute, memory or writeback.
- R9: dec_stall[i] is 1 whenever back_sys[i] reports a system call in execute, memory or writeback.
- R10: When several running cores start the same idle core in one cycle, the lowest-numbered caller wins. Every other caller gets spawn_err and no R1 write.
- R11: A start aimed at a core whose run flag is already 1 causes no PC load and no R1 write. It pulses spawn_err of the caller.
- R12: Immediates other than 1..NCORES-1, 10 and 11 have no effect. Writeback calls from cores whose run flag is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_sys_valid | input | NCORES | A system call is in writeback of core i |
| wb_sys_imm | input | NCORES x IMM_W | Immediate of each core's call |
| wb_sys_pc | input | NCORES x PC_W | PC of each core's calling instruction |
| wb_sys_r1 | input | NCORES x DW | R1 value of each calling core |
| dec_sys | input | NCORES | Decode stage holds a system call |
| back_busy | input | NCORES | Any instruction in execute, memory or writeback |
| back_sys | input | NCORES | A system call is in execute, memory or writeback |
| run | output | NCORES | Per-core run flag |
| all_halted | output | 1 | Every core is stopped |
| pc_load_en | output | NCORES | Load the PC of core i |
| pc_load_val | output | NCORES x PC_W | PC value to load |
| r1_we | output | NCORES | Write R1 of core i |
| r1_wdata | output | NCORES x DW | R1 value to write |
| print_en | output | NCORES | Console-output strobe of core i |
| print_data | output | NCORES x DW | Value to print |
| spawn_err | output | NCORES | Start request from core i was refused |
| dec_stall | output | NCORES | Hold the decode stage of core i |

## Verification
The hardest situation to reach is two running cores aiming at the same idle core in the same cycle, because at least two cores must already be running and both must retire a start call together. The directed phase builds this state on purpose. It first starts core 1, then has cores 0 and 1 both target core 2. The random phase draws start immediates often, and it re-enters reset only after every core has halted. This keeps several cores running for long stretches, so collisions and starts aimed at running cores keep recurring.

// File: rtl/crc_pkg.sv
// Shared definitions for the run-state controller.
// Assumes immediates of at most 32 bits and a core count below the halt code.
package crc_pkg;
    localparam int IMM_W_DEF  = 24;
    localparam int HALT_CODE  = 10;
    localparam int PRINT_CODE = 11;

    typedef enum logic [1:0] {
        SC_NONE,
        SC_SPAWN,
        SC_HALT,
        SC_PRINT
    } sc_kind_e;
endpackage

// File: rtl/crc_sys_decode.sv
// Classifies one core's writeback system call.
// Assumes: a call from a core that is not running is discarded here.
module crc_sys_decode
    import crc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int IMM_W  = IMM_W_DEF,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic             valid,
    input  logic             live,
    input  logic [IMM_W-1:0] imm,
    output sc_kind_e         kind,
    output logic [CW-1:0]    target
);
    // Map the immediate onto an action; unknown codes become no-ops.
    always_comb begin
        kind   = SC_NONE;
        target = imm[CW-1:0];
        if (valid && live) begin
            if (imm == IMM_W'(HALT_CODE))
                kind = SC_HALT;
            else if (imm == IMM_W'(PRINT_CODE))
                kind = SC_PRINT;
            else if (imm != '0 && imm < IMM_W'(NCORES))
                kind = SC_SPAWN;
        end
    end
endmodule

// File: rtl/crc_spawn_arb.sv
// Resolves start requests for each target core.
// The lowest-numbered caller wins. Requests aimed at a running core,
// or that lose arbitration, are refused.
module crc_spawn_arb #(
    parameter int NCORES = 4,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic [NCORES-1:0]         spawn_req,
    input  logic [NCORES-1:0][CW-1:0] target,
    input  logic [NCORES-1:0]         run,
    output logic [NCORES-1:0]         grant,
    output logic [NCORES-1:0]         err,
    output logic [NCORES-1:0]         start,
    output logic [NCORES-1:0][CW-1:0] start_src
);
    // Scan callers in ascending order for every target.
    always_comb begin
        grant     = '0;
        err       = '0;
        start     = '0;
        start_src = '0;
        for (int t = 0; t < NCORES; t++) begin
            for (int c = 0; c < NCORES; c++) begin
                if (spawn_req[c] && target[c] == CW'(t)) begin
                    if (!run[t] && !start[t]) begin
                        start[t]     = 1'b1;
                        start_src[t] = CW'(c);
                        grant[c]     = 1'b1;
                    end else begin
                        err[c] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/crc_serialize.sv
// Decode-stage hold that lets a system call occupy its pipeline alone.
// Assumes the pipeline reports occupancy of its later stages.
module crc_serialize #(
    parameter int NCORES = 4
) (
    input  logic [NCORES-1:0] dec_sys,
    input  logic [NCORES-1:0] back_busy,
    input  logic [NCORES-1:0] back_sys,
    output logic [NCORES-1:0] dec_stall
);
    for (genvar g = 0; g < NCORES; g++) begin : g_core
        // Hold decode while a call waits for the drain or while a call is ahead.
        assign dec_stall[g] = (dec_sys[g] & back_busy[g]) | back_sys[g];
    end
endmodule

// File: rtl/core_run_ctrl.sv
// Run-state controller for NCORES cores.
// It acts on writeback system calls in the cycle they are presented and
// updates the run flags at the following edge.
// Assumes: a core whose run flag is 0 presents no real writeback call.
module core_run_ctrl
    import crc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int IMM_W  = IMM_W_DEF,
    parameter int PC_W   = 32,
    parameter int DW     = 32,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NCORES-1:0]              wb_sys_valid,
    input  logic [NCORES-1:0][IMM_W-1:0]   wb_sys_imm,
    input  logic [NCORES-1:0][PC_W-1:0]    wb_sys_pc,
    input  logic [NCORES-1:0][DW-1:0]      wb_sys_r1,
    input  logic [NCORES-1:0]              dec_sys,
    input  logic [NCORES-1:0]              back_busy,
    input  logic [NCORES-1:0]              back_sys,
    output logic [NCORES-1:0]              run,
    output logic                           all_halted,
    output logic [NCORES-1:0]              pc_load_en,
    output logic [NCORES-1:0][PC_W-1:0]    pc_load_val,
    output logic [NCORES-1:0]              r1_we,
    output logic [NCORES-1:0][DW-1:0]      r1_wdata,
    output logic [NCORES-1:0]              print_en,
    output logic [NCORES-1:0][DW-1:0]      print_data,
    output logic [NCORES-1:0]              spawn_err,
    output logic [NCORES-1:0]              dec_stall
);
    logic [NCORES-1:0]         run_q;
    sc_kind_e                  kind [NCORES];
    logic [NCORES-1:0][CW-1:0] tgt;
    logic [NCORES-1:0]         spawn_req;
    logic [NCORES-1:0]         halt_req;
    logic [NCORES-1:0]         grant;
    logic [NCORES-1:0]         start;
    logic [NCORES-1:0][CW-1:0] src;

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        crc_sys_decode #(.NCORES(NCORES), .IMM_W(IMM_W)) u_dec (
            .valid (wb_sys_valid[g]),
            .live  (run_q[g]),
            .imm   (wb_sys_imm[g]),
            .kind  (kind[g]),
            .target(tgt[g])
        );
        assign spawn_req[g]   = (kind[g] == SC_SPAWN);
        assign halt_req[g]    = (kind[g] == SC_HALT);
        assign print_en[g]    = (kind[g] == SC_PRINT);
        assign print_data[g]  = wb_sys_r1[g];
        assign pc_load_en[g]  = start[g];
        assign pc_load_val[g] = wb_sys_pc[src[g]] + PC_W'(4);
        assign r1_we[g]       = grant[g] | start[g];
        assign r1_wdata[g]    = start[g] ? DW'(1) : '0;
    end

    crc_spawn_arb #(.NCORES(NCORES)) u_arb (
        .spawn_req(spawn_req),
        .target   (tgt),
        .run      (run_q),
        .grant    (grant),
        .err      (spawn_err),
        .start    (start),
        .start_src(src)
    );

    crc_serialize #(.NCORES(NCORES)) u_ser (
        .dec_sys  (dec_sys),
        .back_busy(back_busy),
        .back_sys (back_sys),
        .dec_stall(dec_stall)
    );

    // Run flags: core 0 boots, starts set a flag, halts clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= NCORES'(1);
        else
            run_q <= (run_q | start) & ~halt_req;
    end

    assign run        = run_q;
    assign all_halted = ~|run_q;
endmodule

// File: rtl/crc_checker.sv
// Property checker for core_run_ctrl, attached through bind.
module crc_checker
    import crc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int IMM_W  = IMM_W_DEF,
    parameter int PC_W   = 32,
    parameter int DW     = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NCORES-1:0]            wb_sys_valid,
    input logic [NCORES-1:0][IMM_W-1:0] wb_sys_imm,
    input logic [NCORES-1:0]            back_sys,
    input logic [NCORES-1:0]            run,
    input logic                         all_halted,
    input logic [NCORES-1:0]            pc_load_en,
    input logic [NCORES-1:0]            r1_we,
    input logic [NCORES-1:0][DW-1:0]    r1_wdata,
    input logic [NCORES-1:0]            spawn_err,
    input logic [NCORES-1:0]            dec_stall
);
    logic seen;

    // Marks the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_boot_core0: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (run == NCORES'(1)));

    a_r6_halted_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        all_halted |=> all_halted);

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
            pc_load_en[g] |-> !run[g]);
        a_r3_caller_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (r1_we[g] && run[g]) |-> (r1_wdata[g] == '0));
        a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
            pc_load_en[g] |=> run[g]);
        a_r5_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_sys_valid[g] && run[g] && wb_sys_imm[g] == IMM_W'(HALT_CODE)) |=> !run[g]);
        a_r9_back_stall: assert property (@(posedge clk) disable iff (!rst_n)
            back_sys[g] |-> dec_stall[g]);
        a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            spawn_err[g] |-> !r1_we[g]);
    end
endmodule

bind core_run_ctrl crc_checker #(
    .NCORES(NCORES), .IMM_W(IMM_W), .PC_W(PC_W), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_sys_valid(wb_sys_valid), .wb_sys_imm(wb_sys_imm),
    .back_sys(back_sys), .run(run), .all_halted(all_halted), .pc_load_en(pc_load_en),
    .r1_we(r1_we), .r1_wdata(r1_wdata), .spawn_err(spawn_err), .dec_stall(dec_stall)
);

// File: tb/core_run_ctrl_bench.sv
// Bench for core_run_ctrl: a directed phase, then seeded random stimulus
// checked against a bench-side model.
module core_run_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int IW    = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]          v, dsys, bbusy, bsys;
    logic [N-1:0][IW-1:0]  imm;
    logic [N-1:0][31:0]    pc, r1;
    logic [N-1:0]          run, pcen, we, pen, err, stall;
    logic                  allh;
    logic [N-1:0][31:0]    pcv, wd, pd;

    logic [N-1:0]          mrun, e_pcen, e_we, e_pen, e_err, e_stall, e_halt, e_next;
    logic [N-1:0][31:0]    e_pcv, e_wd, e_pd;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    core_run_ctrl u_core_run_ctrl (
        .clk(clk), .rst_n(rst_n), .wb_sys_valid(v), .wb_sys_imm(imm), .wb_sys_pc(pc),
        .wb_sys_r1(r1), .dec_sys(dsys), .back_busy(bbusy), .back_sys(bsys), .run(run),
        .all_halted(allh), .pc_load_en(pcen), .pc_load_val(pcv), .r1_we(we),
        .r1_wdata(wd), .print_en(pen), .print_data(pd), .spawn_err(err), .dec_stall(stall)
    );

    task automatic chk(bit ok, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Expected outputs from the requirements and the current model state.
    task automatic model_eval();
        logic [N-1:0] sreq;
        e_pcen = '0; e_we = '0; e_pen = '0; e_err = '0; e_halt = '0; sreq = '0;
        e_pcv = '0; e_wd = '0; e_pd = '0;
        for (int c = 0; c < N; c++) begin
            if (v[c] && mrun[c]) begin
                if (imm[c] == IW'(10)) e_halt[c] = 1'b1;
                else if (imm[c] == IW'(11)) begin e_pen[c] = 1'b1; e_pd[c] = r1[c]; end
                else if (imm[c] >= IW'(1) && imm[c] < IW'(N)) sreq[c] = 1'b1;
            end
        end
        for (int c = 0; c < N; c++) begin
            if (sreq[c]) begin
                int t = int'(imm[c]);
                if (!mrun[t] && !e_pcen[t]) begin
                    e_pcen[t] = 1'b1; e_pcv[t] = pc[c] + 32'd4;
                    e_we[t] = 1'b1; e_wd[t] = 32'd1;
                    e_we[c] = 1'b1; e_wd[c] = 32'd0;
                end else e_err[c] = 1'b1;
            end
            e_stall[c] = bsys[c] | (dsys[c] & bbusy[c]);
        end
        e_next = (mrun | e_pcen) & ~e_halt;
    endtask

    function automatic logic [127:0] msk(logic [N-1:0] en, logic [N-1:0][31:0] d);
        logic [N-1:0][31:0] o = '0;
        for (int i = 0; i < N; i++) if (en[i]) o[i] = d[i];
        return o;
    endfunction

    // Inputs are already driven at a falling edge; check, then advance one cycle.
    task automatic step(string tag);
        #1;
        chk(run == mrun, {tag, " R4 R5 run"}, 128'(run), 128'(mrun));
        chk(allh == (mrun == '0), {tag, " R6 all_halted"}, 128'(allh), 128'(mrun == '0));
        model_eval();
        chk(pcen == e_pcen && msk(pcen, pcv) == msk(e_pcen, e_pcv), {tag, " R2 pc load"},
            {msk(pcen, pcv)}, {msk(e_pcen, e_pcv)});
        chk(we == e_we && msk(we, wd) == msk(e_we, e_wd), {tag, " R3 r1 write"},
            {msk(we, wd)}, {msk(e_we, e_wd)});
        chk(pen == e_pen && msk(pen, pd) == msk(e_pen, e_pd), {tag, " R7 print"},
            {msk(pen, pd)}, {msk(e_pen, e_pd)});
        chk(err == e_err, {tag, " R10 R11 spawn_err"}, 128'(err), 128'(e_err));
        chk(stall == e_stall, {tag, " R8 R9 dec_stall"}, 128'(stall), 128'(e_stall));
        @(posedge clk);
        mrun = e_next;
        @(negedge clk);
    endtask

    task automatic idle();
        v = '0; dsys = '0; bbusy = '0; bsys = '0; imm = '0; pc = '0; r1 = '0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mrun = N'(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        #1;
        chk(run == 4'b0001 && !allh, "R1 reset state", 128'({allh, run}), 128'(5'b00001));
        @(negedge clk);
        // R2 R3 R4: core 0 starts core 1.
        idle(); v[0] = 1; imm[0] = 1; pc[0] = 32'h100;
        step("R2 start core1");
        // R11: start aimed at running core 1.
        idle(); v[0] = 1; imm[0] = 1; pc[0] = 32'h200;
        step("R11 start running");
        // R10: cores 0 and 1 both aim at core 2.
        idle(); v[0] = 1; imm[0] = 2; pc[0] = 32'h300; v[1] = 1; imm[1] = 2; pc[1] = 32'h400;
        step("R10 collision");
        // R7 and R12: print, unknown code, call from idle core 3.
        idle(); v[1] = 1; imm[1] = 11; r1[1] = 32'h1234fffe; v[2] = 1; imm[2] = 7;
        v[3] = 1; imm[3] = 1; pc[3] = 32'h500;
        step("R7 R12 print unknown idle");
        // R8 R9: stall patterns.
        for (int k = 0; k < 8; k++) begin
            idle(); dsys = 4'(k); bbusy = 4'(k >> 1); bsys = 4'(k == 5 ? 4'b1010 : 4'b0);
            step("R8 R9 stall");
        end
        // R5 R6: halt every running core at once, then hold.
        idle(); v[0] = 1; v[1] = 1; v[2] = 1; imm[0] = 10; imm[1] = 10; imm[2] = 10;
        step("R5 halt all");
        idle(); step("R6 stays halted");
        // Random phase.
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            if (mrun == '0) do_reset();
            for (int c = 0; c < N; c++) begin
                int sel = int'($urandom_range(0, 7));
                v[c] = ($urandom_range(0, 2) == 0);
                case (sel)
                    0, 1:    imm[c] = IW'($urandom_range(1, 3));
                    2:       imm[c] = 10;
                    3:       imm[c] = 11;
                    4:       imm[c] = 0;
                    default: imm[c] = IW'($urandom);
                endcase
                if (sel == 2 && $urandom_range(0, 3) != 0) v[c] = 1'b0;
                pc[c] = $urandom; r1[c] = $urandom;
                dsys[c] = $urandom_range(0, 1) == 1; bbusy[c] = $urandom_range(0, 1) == 1;
                bsys[c] = $urandom_range(0, 3) == 0;
            end
            step("random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule